// File: doc/BRIEF.md
# Hybrid Parity/Disjunction Clause Evaluator

This block scores a Boolean formula against a candidate assignment once per clock. It keeps a programmable incidence matrix with one row per clause slot and one column per literal position, plus a kind bit per row. The kind bit marks the row as a parity (XOR) clause or a disjunction (OR) clause. Each cycle it forms the literal vector from the variable inputs and counts the connected true literals in every row. From the count alone it derives three registered flags per clause. Violated marks an unsatisfied clause. Make marks a clause that one flip of any of its variables would satisfy. Break marks a clause that one flip could falsify.

A local-search engine reads the make and break flags to build per-variable gains. It reads the all-satisfied flag to stop. Software or a loader fills the matrix one row at a time through the write port. A row with no connections is an idle slot and stays silent.

Top module: `hybrid_clause_eval`

## Requirements
- R1: While reset is held and after it, every violated, make and break flag is 0, all_sat is 1, and every row and kind bit is cleared.
- R2: Variable j drives literal position 2j with its own value and position 2j+1 with its complement; a clause count is the number of its connected positions holding 1.
- R3: When wr_en is 1 at a rising edge and wr_idx is below NCLS, that clause slot takes wr_row as its connections and wr_xor as its kind (1 = parity, 0 = disjunction); evaluation uses the new row from the next edge on.
- R4: A parity clause is violated and make-eligible when its count is even, and break-eligible (not violated) when its count is odd.
- R5: A disjunction clause is violated and make-eligible when its count is 0, break-eligible when its count is 1, and has no flag set when its count is 2 or more.
- R6: A clause slot with no connections never raises violated, make or break, whatever its kind and the variables.
- R7: all_sat is 1 exactly when no violated flag is set, and it updates in the same cycle as the flags.
- R8: All outputs are registered: the flags after a rising edge reflect the variables and matrix as they were just before that edge.
- R9: A clause may hold up to KMAX connected literals, and its parity is judged over all of them.
- R10: For every clause, make and break are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vars_i | input | NVAR | Current variable assignment, bit j is variable j |
| wr_en_i | input | 1 | Load one clause row this cycle |
| wr_idx_i | input | $clog2(NCLS) | Clause slot to load |
| wr_row_i | input | 2*NVAR | Connection mask over literal positions |
| wr_xor_i | input | 1 | Kind of loaded clause: 1 parity, 0 disjunction |
| viol_o | output | NCLS | Per-clause violated flag |
| make_o | output | NCLS | Per-clause make-eligible flag |
| brk_o | output | NCLS | Per-clause break-eligible flag |
| all_sat_o | output | 1 | No clause is violated |

## Verification
The bench builds the block with eight variables, six clause slots and a fifteen-literal limit. This gives a sixteen-position literal row, so one row can connect fifteen positions, reach a count of seven or eight, and test the parity judgement at the length limit. Six slots are enough to hold two parity clauses, two disjunction clauses, a full-length clause and an idle slot together. One vector can then drive every count class at once. A rewrite of the kind bit on an unchanged row, and a load-then-clear of the idle slot, cover kind selection and the one-edge load latency.

// File: rtl/hce_pkg.sv
package hce_pkg;
    // Kind bit stored per clause slot
    typedef enum logic {
        KIND_OR  = 1'b0,
        KIND_XOR = 1'b1
    } clause_kind_e;

    // Number of bits needed to hold a count up to max_len
    function automatic int cnt_width(input int max_len);
        return $clog2(max_len + 1);
    endfunction
endpackage

// File: rtl/hce_store.sv
module hce_store #(
    parameter int NCLS = 6,
    parameter int LW   = 16,
    localparam int IW  = (NCLS > 1) ? $clog2(NCLS) : 1
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       wr_en_i,
    input  logic [IW-1:0]              wr_idx_i,
    input  logic [LW-1:0]              wr_row_i,
    input  logic                       wr_xor_i,
    output logic [NCLS-1:0][LW-1:0]    rows_o,
    output logic [NCLS-1:0]            kind_o
);
    typedef struct packed {
        logic [NCLS-1:0][LW-1:0] rows;
        logic [NCLS-1:0]         kind;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NCLS; i++) begin
            if (wr_en_i && (32'(wr_idx_i) == i)) begin
                st_d.rows[i] = wr_row_i;
                st_d.kind[i] = wr_xor_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rows_o = st_q.rows;
    assign kind_o = st_q.kind;

    for (genvar g = 0; g < NCLS; g++) begin : g_chk
        // R3
        row_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_en_i && (32'(wr_idx_i) == g)) |=>
                (rows_o[g] == $past(wr_row_i) && kind_o[g] == $past(wr_xor_i)));
    end
endmodule

// File: rtl/hce_clause.sv
module hce_clause
    import hce_pkg::*;
#(
    parameter int LW   = 16,
    parameter int KMAX = 15,
    localparam int CW  = cnt_width(KMAX)
) (
    input  logic [LW-1:0] row_i,
    input  logic [LW-1:0] lits_i,
    input  logic          kind_i,
    output logic          viol_o,
    output logic          make_o,
    output logic          brk_o
);
    logic [LW-1:0] hit;
    logic [CW-1:0] cnt;
    logic          empty;

    assign hit   = row_i & lits_i;
    assign empty = (row_i == '0);

    always_comb begin
        cnt = '0;
        for (int p = 0; p < LW; p++) cnt = cnt + CW'(hit[p]);
    end

    always_comb begin
        viol_o = 1'b0;
        make_o = 1'b0;
        brk_o  = 1'b0;
        if (!empty) begin
            if (clause_kind_e'(kind_i) == KIND_XOR) begin
                make_o = ~cnt[0];
                brk_o  = cnt[0];
                viol_o = ~cnt[0];
            end else begin
                make_o = (cnt == '0);
                brk_o  = (cnt == CW'(1));
                viol_o = (cnt == '0);
            end
        end
    end
endmodule

// File: rtl/hybrid_clause_eval.sv
module hybrid_clause_eval #(
    parameter int NVAR = 8,
    parameter int NCLS = 6,
    parameter int KMAX = 15,
    localparam int LW  = 2 * NVAR,
    localparam int IW  = (NCLS > 1) ? $clog2(NCLS) : 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NVAR-1:0] vars_i,
    input  logic            wr_en_i,
    input  logic [IW-1:0]   wr_idx_i,
    input  logic [LW-1:0]   wr_row_i,
    input  logic            wr_xor_i,
    output logic [NCLS-1:0] viol_o,
    output logic [NCLS-1:0] make_o,
    output logic [NCLS-1:0] brk_o,
    output logic            all_sat_o
);
    typedef struct packed {
        logic [NCLS-1:0] viol;
        logic [NCLS-1:0] make;
        logic [NCLS-1:0] brk;
        logic            all_sat;
    } flags_t;

    localparam flags_t FLAGS_RST = '{viol: '0, make: '0, brk: '0, all_sat: 1'b1};

    logic [NCLS-1:0][LW-1:0] rows;
    logic [NCLS-1:0]         kind;
    logic [LW-1:0]           lits;
    logic [NCLS-1:0]         viol_c, make_c, brk_c;
    flags_t                  fl_d, fl_q;

    // Literal vector: true value at even position, complement at odd
    for (genvar j = 0; j < NVAR; j++) begin : g_lit
        assign lits[2*j]   = vars_i[j];
        assign lits[2*j+1] = ~vars_i[j];
    end

    hce_store #(.NCLS(NCLS), .LW(LW)) u_store (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_idx_i (wr_idx_i),
        .wr_row_i (wr_row_i),
        .wr_xor_i (wr_xor_i),
        .rows_o   (rows),
        .kind_o   (kind)
    );

    for (genvar i = 0; i < NCLS; i++) begin : g_cls
        hce_clause #(.LW(LW), .KMAX(KMAX)) u_cls (
            .row_i  (rows[i]),
            .lits_i (lits),
            .kind_i (kind[i]),
            .viol_o (viol_c[i]),
            .make_o (make_c[i]),
            .brk_o  (brk_c[i])
        );
    end

    always_comb begin
        fl_d         = fl_q;
        fl_d.viol    = viol_c;
        fl_d.make    = make_c;
        fl_d.brk     = brk_c;
        fl_d.all_sat = ~|viol_c;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fl_q <= FLAGS_RST;
        else         fl_q <= fl_d;
    end

    assign viol_o    = fl_q.viol;
    assign make_o    = fl_q.make;
    assign brk_o     = fl_q.brk;
    assign all_sat_o = fl_q.all_sat;

    // R10
    make_brk_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (make_o & brk_o) == '0);

    // R4
    make_viol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (make_o & ~viol_o) == '0);

    // R7
    all_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        all_sat_o == (viol_o == '0));

    for (genvar i = 0; i < NCLS; i++) begin : g_achk
        // R6
        empty_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rows[i] == '0) |=> !(viol_o[i] || make_o[i] || brk_o[i]));
    end
endmodule

// File: tb/tb_hybrid_clause_eval.sv
module tb_hybrid_clause_eval;
    localparam int NVAR = 8;
    localparam int NCLS = 6;
    localparam int KMAX = 15;
    localparam int LW   = 2 * NVAR;
    localparam int IW   = $clog2(NCLS);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NVAR-1:0] vars = '0;
    logic            wr_en = 1'b0;
    logic [IW-1:0]   wr_idx = '0;
    logic [LW-1:0]   wr_row = '0;
    logic            wr_xor = 1'b0;
    logic [NCLS-1:0] viol, make, brk;
    logic            all_sat;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    hybrid_clause_eval #(.NVAR(NVAR), .NCLS(NCLS), .KMAX(KMAX)) dut (
        .clk_i(clk), .rst_ni(rst_n), .vars_i(vars),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_row_i(wr_row), .wr_xor_i(wr_xor),
        .viol_o(viol), .make_o(make), .brk_o(brk), .all_sat_o(all_sat)
    );

    // {vars, viol, make, brk, all_sat} against the loaded formula
    localparam logic [26:0] TBL [6] = '{
        {8'h00, 6'h01, 6'h01, 6'h1A, 1'b0},
        {8'hFF, 6'h14, 6'h14, 6'h0B, 1'b0},
        {8'h61, 6'h00, 6'h00, 6'h19, 1'b1},
        {8'h8E, 6'h13, 6'h13, 6'h0C, 1'b0},
        {8'h10, 6'h01, 6'h01, 6'h1E, 1'b0},
        {8'h18, 6'h05, 6'h05, 6'h1A, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [LW-1:0] row, input logic kx);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_row = row; wr_xor = kx;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // drive vars, then sample one time unit after the next rising edge
    task automatic apply(input logic [NVAR-1:0] v);
        @(negedge clk);
        vars = v;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_all(input string req, input logic [5:0] ev, input logic [5:0] em,
                           input logic [5:0] eb, input logic es);
        chk({req, " viol"}, 32'(viol), 32'(ev));
        chk({req, " make"}, 32'(make), 32'(em));
        chk({req, " brk"},  32'(brk),  32'(eb));
        chk({req, " all_sat"}, 32'(all_sat), 32'(es));
    endtask

    initial begin
        #20000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk_all("R1 in reset", 6'h00, 6'h00, 6'h00, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        // R6 R1: empty matrix after reset stays quiet for any vars
        apply(8'h00);
        chk_all("R6 empty matrix", 6'h00, 6'h00, 6'h00, 1'b1);
        apply(8'hA5);
        chk_all("R6 empty matrix", 6'h00, 6'h00, 6'h00, 1'b1);

        // Formula: R2 positions 2j true, 2j+1 complement
        load(0, 16'h0015, 1'b1);  // parity of x0 x1 x2
        load(1, 16'h0009, 1'b0);  // x0 or ~x1
        load(2, 16'h0280, 1'b0);  // ~x3 or ~x4
        load(3, 16'h2400, 1'b1);  // parity of x5 ~x6
        load(4, 16'h7FFF, 1'b1);  // R9: 15-literal parity clause
        // slot 5 stays empty (R6)

        // R2 R4 R5 R9 R7 R10: table walk
        foreach (TBL[k]) begin
            apply(TBL[k][26:19]);
            chk_all($sformatf("R4/R5 vec%0d", k), TBL[k][18:13], TBL[k][12:7],
                    TBL[k][6:1], TBL[k][0]);
            chk("R10 exclusive", 32'(make & brk), 32'h0);
        end

        // R3 R8: load slot 5 as OR of x0; flags follow one edge later
        apply(8'h00);
        chk("R8 before load", 32'(viol[5]), 32'h0);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd5; wr_row = 16'h0001; wr_xor = 1'b0;
        @(posedge clk); #1;
        chk("R8 load edge not yet used", 32'(viol[5]), 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk); #1;
        chk("R3 loaded OR clause violated", 32'(viol[5]), 32'h1);
        chk("R3 all_sat low", 32'(all_sat), 32'h0);
        apply(8'h01);
        chk("R5 count one break", 32'(brk[5]), 32'h1);

        // R3 R4: same row for slot 1 but parity kind
        load(1, 16'h0009, 1'b1);
        apply(8'h00);  // count 1: odd
        chk("R4 kind switch odd", {30'h0, viol[1], brk[1]}, 32'h1);
        apply(8'h02);  // count 0: even
        chk("R4 kind switch even", {30'h0, viol[1], make[1]}, 32'h3);
        apply(8'h01);  // count 2: even, parity violated
        chk("R4 count two", {30'h0, viol[1], make[1]}, 32'h3);

        // R6: clear slot 5 again, it goes silent
        load(5, 16'h0000, 1'b1);
        apply(8'h00);
        chk("R6 cleared slot", {29'h0, viol[5], make[5], brk[5]}, 32'h0);

        // R3: out-of-range index leaves all slots unchanged
        load(6, 16'hFFFF, 1'b0);
        apply(8'h00);
        chk("R3 out of range idx", {29'h0, viol[5], make[5], brk[5]}, 32'h0);
        chk("R3 slot0 unchanged", 32'(viol[0]), 32'h1);

        // R1: reset mid-run clears flags and matrix
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk_all("R1 async reset", 6'h00, 6'h00, 6'h00, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        apply(8'h00);
        chk_all("R1 matrix cleared", 6'h00, 6'h00, 6'h00, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule